// File: doc/BRIEF.md
# Receive Ring Write Controller

This block steers incoming Ethernet receive bytes into a circular region of a shared 8-Kbyte byte-addressed buffer. The host fixes the region with an inclusive first address and an inclusive last address, and it may place the region across the top of memory so that it wraps through address zero. The block walks a working write address through the region one byte at a time. It folds from the last address back to the first and issues one single-port memory write for each byte it accepts.

The host owns a guard address inside the region, and the block never writes that byte. When the working address reaches the guard, the packet is marked as overflowed and every remaining byte of it is dropped, so data the host has not yet consumed stays intact. A second pointer, which the host can only read, marks the end of the last packet that arrived intact. It moves forward only on a good end-of-packet strobe. A bad strobe, or any end strobe that closes an overflowed packet, returns the working address to that pointer. A saturating count of packets held in the ring goes up on each committed packet and goes down by one on each host decrement command.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the first address is 0000h, the last address is 1FFFh, both the working address and the committed pointer are 0000h, the packet count is 0, and no memory write is issued.
- R2: In a cycle where receive is enabled, `in_valid` is high, neither end strobe is high and the working address differs from the guard, the byte is written. On the next cycle `mem_we` is 1, `mem_addr` holds the working address and `mem_wdata` holds the byte, and the working address has advanced. A byte presented in the same cycle as an end strobe is not written.
- R3: The address after the last address is the first address. Every other address is followed by address plus one, taken modulo 2^13, so a region whose first address is numerically above its last address crosses 1FFFh to 0000h.
- R4: `free_bytes` equals the number of region positions from the working address up to, but not including, the guard, counted in ring order. It is 0 when the two are equal.
- R5: A byte that arrives when the working address equals the guard is dropped and marks the packet as overflowed. All later bytes of that packet are dropped too, and the guard address is never written.
- R6: A good strobe (`pkt_good`=1, `pkt_bad`=0) on a packet that has not overflowed copies the working address into `wr_ptr` and raises the packet count by one.
- R7: A bad strobe (`pkt_bad`=1, which takes priority over `pkt_good`), or any end strobe on an overflowed packet, returns the working address to `wr_ptr`. It leaves `wr_ptr` and the count unchanged and clears the overflow mark.
- R8: Host writes to the first or last address are ignored while receive is enabled. While receive is disabled they take effect on the next cycle, and both the working address and `wr_ptr` move to the (new) first address.
- R9: The packet count saturates at 255. A decrement acts once per rising edge of `pkt_dec`, so holding the command high decrements only once, and it is ignored when the count is 0. An increment and a decrement in the same cycle leave the count unchanged, except that from 0 the result is 1.
- R10: While receive is disabled, bytes and end strobes have no effect: no memory write is issued, and the working address, `wr_ptr` and the count stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| pkt_good | input | 1 | End-of-packet strobe, packet intact |
| pkt_bad | input | 1 | End-of-packet strobe, packet rejected |
| host_wr_first | input | 1 | Host write strobe for the first address |
| host_first | input | 13 | New first address |
| host_wr_last | input | 1 | Host write strobe for the last address |
| host_last | input | 13 | New last address |
| host_guard | input | 13 | Guard address, never written |
| pkt_dec | input | 1 | Packet decrement command |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 13 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| first_addr | output | 13 | Current first address of the region |
| last_addr | output | 13 | Current last address of the region |
| wr_ptr | output | 13 | Committed write pointer |
| free_bytes | output | 14 | Writable bytes before the guard |
| pkt_count | output | 8 | Packets held in the ring |

## Verification
The case that is hardest to reach from the ports is a packet that runs into the guard partway through, after the working address has already wrapped across 1FFFh, and then ends with a good strobe. Here the block has to discard the packet and roll back across the wrap point. A directed sequence builds this case deliberately: it places a small straddling region, puts the guard a few bytes past the wrap and sends a longer packet. A seeded random phase then runs in a region of a few dozen bytes with the guard moving, so the wrap, overflow, rollback and saturation cases occur many times in varied orders.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
   localparam int unsigned MEM_ADDR_W = 13;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned COUNT_W    = 8;

   typedef enum logic [1:0] {
      END_NONE = 2'd0,
      END_GOOD = 2'd1,
      END_BAD  = 2'd2
   } pkt_end_e;
endpackage

// File: rtl/rx_ring_addr.sv
module rx_ring_addr #(
   parameter int unsigned ADDR_W = 13
) (
   input  logic [ADDR_W-1:0] first_i,
   input  logic [ADDR_W-1:0] last_i,
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [ADDR_W-1:0] guard_i,
   output logic [ADDR_W-1:0] next_o,
   output logic [ADDR_W:0]   free_o
);
   localparam int unsigned FREE_W = ADDR_W + 1;

   logic [ADDR_W-1:0] cur_ofs;
   logic [ADDR_W-1:0] guard_ofs;
   logic [ADDR_W-1:0] span_m1;
   logic [FREE_W-1:0] ring_size;
   logic [FREE_W-1:0] gap;

   always_comb begin
      cur_ofs   = cur_i - first_i;
      guard_ofs = guard_i - first_i;
      span_m1   = last_i - first_i;
      ring_size = {1'b0, span_m1} + FREE_W'(1);
      gap       = {1'b0, guard_ofs} - {1'b0, cur_ofs};
      if (guard_ofs >= cur_ofs) begin
         free_o = gap;
      end else begin
         free_o = gap + ring_size;
      end
      if (cur_i == last_i) begin
         next_o = first_i;
      end else begin
         next_o = cur_i + ADDR_W'(1);
      end
   end
endmodule

// File: rtl/rx_ring_cursor.sv
module rx_ring_cursor
   import rx_ring_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] INIT_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  pkt_end_e          end_kind,
   input  logic              region_load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [ADDR_W-1:0] next_addr,
   input  logic [ADDR_W-1:0] guard,
   output logic [ADDR_W-1:0] work_addr,
   output logic [ADDR_W-1:0] commit_addr,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              commit_pulse
);
   logic overflowed;
   logic byte_in;
   logic has_room;
   logic closing;

   always_comb begin
      byte_in      = rx_en && in_valid && (end_kind == END_NONE);
      has_room     = (work_addr != guard);
      closing      = rx_en && (end_kind != END_NONE);
      wr_req       = byte_in && has_room && !overflowed;
      wr_addr      = work_addr;
      wr_data      = in_data;
      commit_pulse = closing && (end_kind == END_GOOD) && !overflowed && !region_load;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_addr   <= INIT_ADDR;
         commit_addr <= INIT_ADDR;
         overflowed  <= 1'b0;
      end else if (region_load) begin
         work_addr   <= load_addr;
         commit_addr <= load_addr;
         overflowed  <= 1'b0;
      end else if (closing) begin
         if (commit_pulse) begin
            commit_addr <= work_addr;
         end else begin
            work_addr <= commit_addr;
         end
         overflowed <= 1'b0;
      end else if (byte_in) begin
         if (wr_req) begin
            work_addr <= next_addr;
         end else begin
            overflowed <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rx_ring_pktcnt.sv
module rx_ring_pktcnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec_cmd,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic dec_seen;
   logic dec_edge;
   logic [CNT_W-1:0] count_nx;

   always_comb begin
      dec_edge = dec_cmd && !dec_seen;
      count_nx = count;
      if (inc && !dec_edge) begin
         if (count != CNT_MAX) count_nx = count + CNT_W'(1);
      end else if (dec_edge && !inc) begin
         if (count != '0) count_nx = count - CNT_W'(1);
      end else if (inc && dec_edge) begin
         if (count == '0) count_nx = CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         dec_seen <= 1'b0;
      end else begin
         count    <= count_nx;
         dec_seen <= dec_cmd;
      end
   end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rx_ring_pkg::*;
#(
   parameter int unsigned ADDR_W   = MEM_ADDR_W,
   parameter int unsigned DATA_W   = BYTE_W,
   parameter int unsigned CNT_W    = COUNT_W,
   parameter bit          WRITE_REG = 1'b1,
   parameter logic [ADDR_W-1:0] INIT_FIRST = '0,
   parameter logic [ADDR_W-1:0] INIT_LAST  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              pkt_good,
   input  logic              pkt_bad,
   input  logic              host_wr_first,
   input  logic [ADDR_W-1:0] host_first,
   input  logic              host_wr_last,
   input  logic [ADDR_W-1:0] host_last,
   input  logic [ADDR_W-1:0] host_guard,
   input  logic              pkt_dec,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] first_addr,
   output logic [ADDR_W-1:0] last_addr,
   output logic [ADDR_W-1:0] wr_ptr,
   output logic [ADDR_W:0]   free_bytes,
   output logic [CNT_W-1:0]  pkt_count
);
   if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_addr_w
      $error("rx_ring_writer: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("rx_ring_writer: DATA_W must be positive");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("rx_ring_writer: CNT_W out of range");
   end

   logic              region_load;
   logic [ADDR_W-1:0] load_addr;
   logic [ADDR_W-1:0] work_addr;
   logic [ADDR_W-1:0] next_addr;
   logic              wr_req;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              commit_pulse;
   pkt_end_e          end_kind;

   always_comb begin
      if (pkt_bad)       end_kind = END_BAD;
      else if (pkt_good) end_kind = END_GOOD;
      else               end_kind = END_NONE;
      region_load = !rx_en && (host_wr_first || host_wr_last);
      load_addr   = host_wr_first ? host_first : first_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_addr <= INIT_FIRST;
         last_addr  <= INIT_LAST;
      end else if (!rx_en) begin
         if (host_wr_first) first_addr <= host_first;
         if (host_wr_last)  last_addr  <= host_last;
      end
   end

   rx_ring_addr #(.ADDR_W(ADDR_W)) u_addr (
      .first_i (first_addr),
      .last_i  (last_addr),
      .cur_i   (work_addr),
      .guard_i (host_guard),
      .next_o  (next_addr),
      .free_o  (free_bytes)
   );

   rx_ring_cursor #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .INIT_ADDR(INIT_FIRST)
   ) u_cursor (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_en        (rx_en),
      .in_valid     (in_valid),
      .in_data      (in_data),
      .end_kind     (end_kind),
      .region_load  (region_load),
      .load_addr    (load_addr),
      .next_addr    (next_addr),
      .guard        (host_guard),
      .work_addr    (work_addr),
      .commit_addr  (wr_ptr),
      .wr_req       (wr_req),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .commit_pulse (commit_pulse)
   );

   rx_ring_pktcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (commit_pulse),
      .dec_cmd (pkt_dec),
      .count   (pkt_count)
   );

   if (WRITE_REG) begin : g_wr_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
         end else begin
            mem_we    <= wr_req;
            mem_addr  <= wr_addr;
            mem_wdata <= wr_data;
         end
      end
   end else begin : g_wr_comb
      always_comb begin
         mem_we    = wr_req;
         mem_addr  = wr_addr;
         mem_wdata = wr_data;
      end
   end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned CNT_W     = 8,
   parameter bit          WRITE_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en,
   input logic              pkt_good,
   input logic              host_wr_first,
   input logic              host_wr_last,
   input logic [ADDR_W-1:0] host_guard,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] first_addr,
   input logic [ADDR_W-1:0] last_addr,
   input logic [ADDR_W-1:0] wr_ptr,
   input logic [CNT_W-1:0]  pkt_count
);
   logic [ADDR_W-1:0] addr_ofs;
   logic [ADDR_W-1:0] span_ofs;
   logic              in_region;

   always_comb begin
      addr_ofs  = mem_addr - first_addr;
      span_ofs  = last_addr - first_addr;
      in_region = (addr_ofs <= span_ofs);
   end

   // R3: every write lands inside the programmed ring
   assert_write_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $stable(first_addr) && $stable(last_addr)) |-> in_region);

   if (WRITE_REG) begin : g_guard_reg
      // R5: the guard byte is never written
      assert_guard_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
         mem_we |-> (mem_addr != $past(host_guard)));
   end else begin : g_guard_comb
      assert_guard_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
         mem_we |-> (mem_addr != host_guard));
   end

   // R6: committed pointer moves only on a good strobe or a region reload
   assert_commit_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wr_ptr) |-> ($past(rx_en && pkt_good) || $past(!rx_en && (host_wr_first || host_wr_last))));

   // R8: ring bounds are frozen while receive runs
   assert_first_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && host_wr_first) |=> $stable(first_addr));
   assert_last_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && host_wr_last) |=> $stable(last_addr));

   // R9: the count moves by at most one per cycle
   assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pkt_count) |-> ((pkt_count == CNT_W'($past(pkt_count) + 1'b1)) ||
                               (pkt_count == CNT_W'($past(pkt_count) - 1'b1))));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(
   .ADDR_W   (ADDR_W),
   .CNT_W    (CNT_W),
   .WRITE_REG(WRITE_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_en        (rx_en),
   .pkt_good     (pkt_good),
   .host_wr_first(host_wr_first),
   .host_wr_last (host_wr_last),
   .host_guard   (host_guard),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr),
   .first_addr   (first_addr),
   .last_addr    (last_addr),
   .wr_ptr       (wr_ptr),
   .pkt_count    (pkt_count)
);

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_en = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_data = '0;
   logic          pkt_good = 1'b0;
   logic          pkt_bad = 1'b0;
   logic          host_wr_first = 1'b0;
   logic [AW-1:0] host_first = '0;
   logic          host_wr_last = 1'b0;
   logic [AW-1:0] host_last = '0;
   logic [AW-1:0] host_guard = '0;
   logic          pkt_dec = 1'b0;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [AW-1:0] first_addr;
   logic [AW-1:0] last_addr;
   logic [AW-1:0] wr_ptr;
   logic [AW:0]   free_bytes;
   logic [7:0]    pkt_count;

   int total = 0;
   int bad = 0;

   // bench reference state
   logic [AW-1:0] m_first, m_last, m_work, m_commit;
   logic [7:0]    m_cnt;
   logic          m_ovf, m_dec_prev;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_ring_writer uut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid), .in_data(in_data),
      .pkt_good(pkt_good), .pkt_bad(pkt_bad), .host_wr_first(host_wr_first),
      .host_first(host_first), .host_wr_last(host_wr_last), .host_last(host_last),
      .host_guard(host_guard), .pkt_dec(pkt_dec), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .first_addr(first_addr), .last_addr(last_addr),
      .wr_ptr(wr_ptr), .free_bytes(free_bytes), .pkt_count(pkt_count)
   );

   function automatic logic [AW-1:0] ring_next(logic [AW-1:0] a, logic [AW-1:0] f, logic [AW-1:0] l);
      return (a == l) ? f : AW'(a + 1);
   endfunction

   function automatic logic [AW:0] ring_free(logic [AW-1:0] w, logic [AW-1:0] g,
                                             logic [AW-1:0] f, logic [AW-1:0] l);
      int size, wi, gi;
      size = int'(AW'(l - f)) + 1;
      wi = int'(AW'(w - f));
      gi = int'(AW'(g - f));
      return (gi >= wi) ? (AW+1)'(gi - wi) : (AW+1)'(gi - wi + size);
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_first = '0; m_last = '1; m_work = '0; m_commit = '0;
      m_cnt = '0; m_ovf = 1'b0; m_dec_prev = 1'b0;
   endtask

   // one clock: predict from current inputs and state, then compare
   task automatic step(string tag);
      logic exp_we, byte_in, closing, good, load, dec_edge, inc;
      logic [AW-1:0] exp_addr;
      logic [7:0] exp_data;
      byte_in  = rx_en && in_valid && !pkt_good && !pkt_bad;
      closing  = rx_en && (pkt_good || pkt_bad);
      good     = pkt_good && !pkt_bad;
      load     = !rx_en && (host_wr_first || host_wr_last);
      exp_we   = byte_in && (m_work != host_guard) && !m_ovf;
      exp_addr = m_work;
      exp_data = in_data;
      inc      = closing && good && !m_ovf && !load;
      dec_edge = pkt_dec && !m_dec_prev;
      m_dec_prev = pkt_dec;
      if (load) begin
         if (host_wr_first) m_first = host_first;
         if (host_wr_last)  m_last  = host_last;
         m_work = m_first; m_commit = m_first; m_ovf = 1'b0;
      end else if (closing) begin
         if (inc) m_commit = m_work; else m_work = m_commit;
         m_ovf = 1'b0;
      end else if (byte_in) begin
         if (exp_we) m_work = ring_next(m_work, m_first, m_last); else m_ovf = 1'b1;
      end
      if (inc && !dec_edge) begin
         if (m_cnt != 8'hFF) m_cnt++;
      end else if (dec_edge && !inc) begin
         if (m_cnt != 0) m_cnt--;
      end else if (inc && dec_edge) begin
         if (m_cnt == 0) m_cnt = 1;
      end
      @(posedge clk);
      #1;
      check({tag, " R2 we"}, 32'(mem_we), 32'(exp_we));
      if (exp_we) begin
         check({tag, " R2/R3 addr"}, 32'(mem_addr), 32'(exp_addr));
         check({tag, " R2 data"}, 32'(mem_wdata), 32'(exp_data));
      end
      check({tag, " R6/R7 wr_ptr"}, 32'(wr_ptr), 32'(m_commit));
      check({tag, " R9 count"}, 32'(pkt_count), 32'(m_cnt));
      check({tag, " R8 first"}, 32'(first_addr), 32'(m_first));
      check({tag, " R8 last"}, 32'(last_addr), 32'(m_last));
      check({tag, " R4 free"}, 32'(free_bytes), 32'(ring_free(m_work, host_guard, m_first, m_last)));
   endtask

   task automatic idle();
      in_valid = 0; pkt_good = 0; pkt_bad = 0; host_wr_first = 0; host_wr_last = 0; pkt_dec = 0;
   endtask

   task automatic set_region(logic [AW-1:0] f, logic [AW-1:0] l, string tag);
      idle(); rx_en = 0;
      host_wr_first = 1; host_first = f; host_wr_last = 1; host_last = l;
      step(tag);
      idle();
   endtask

   task automatic send_bytes(int n, string tag);
      for (int i = 0; i < n; i++) begin
         in_valid = 1; in_data = 8'($urandom);
         step(tag);
      end
      in_valid = 0;
   endtask

   task automatic end_pkt(logic g, logic b, string tag);
      pkt_good = g; pkt_bad = b; in_valid = 1; in_data = 8'hA5;
      step(tag);
      idle();
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      model_reset();
      #(CLK_PERIOD * 3);
      #1;
      // R1: reset state
      check("R1 first", 32'(first_addr), 32'h0000);
      check("R1 last", 32'(last_addr), 32'h1FFF);
      check("R1 wr_ptr", 32'(wr_ptr), 32'h0000);
      check("R1 count", 32'(pkt_count), 32'h0);
      check("R1 we", 32'(mem_we), 32'h0);
      rst_n = 1;
      @(posedge clk); #1;

      // R3: region straddling the top of memory, 32 bytes
      set_region(13'h1FF0, 13'h000F, "R8 load");
      host_guard = 13'h000A;
      rx_en = 1;
      send_bytes(20, "R3 straddle");
      check("R3 working after wrap via free", 32'(free_bytes), 32'(6));
      end_pkt(1, 0, "R6 good");
      check("R6 commit", 32'(wr_ptr), 32'h0004);

      // R5/R7: overflow then good strobe rolls back
      send_bytes(9, "R5 overflow");
      check("R5 no room", 32'(free_bytes), 32'(0));
      end_pkt(1, 0, "R7 ovf end");
      check("R7 rolled back", 32'(wr_ptr), 32'h0004);
      check("R7 count held", 32'(pkt_count), 32'(1));

      // R7: bad packet
      send_bytes(3, "R7 bad body");
      end_pkt(1, 1, "R7 bad end");

      // R8: writes locked while receive is on
      host_wr_first = 1; host_first = 13'h0100; host_wr_last = 1; host_last = 13'h0200;
      step("R8 locked");
      idle();

      // R10: disabled receive ignores bytes and strobes
      rx_en = 0;
      send_bytes(4, "R10 off bytes");
      end_pkt(1, 0, "R10 off strobe");
      rx_en = 1;

      // R9: decrement edge behaviour and saturation
      pkt_dec = 1; step("R9 dec"); step("R9 dec held"); step("R9 dec held2"); pkt_dec = 0; step("R9 release");
      pkt_dec = 1; step("R9 dec zero"); pkt_dec = 0; step("R9 release");
      host_guard = 13'h0003;
      for (int i = 0; i < 260; i++) end_pkt(1, 0, "R9 saturate");
      check("R9 saturated", 32'(pkt_count), 32'd255);
      pkt_good = 1; pkt_dec = 1; step("R9 both at max"); idle(); step("R9 idle");
      pkt_good = 1; step("R9 good"); idle();

      // random phase in small rings
      set_region(13'h1FE8, 13'h000B, "R8 random ring");
      host_guard = 13'h1FF8;
      rx_en = 1;
      for (int c = 0; c < 6000; c++) begin
         int r;
         idle();
         r = int'($urandom % 100);
         in_valid = (r < 60);
         in_data = 8'($urandom);
         pkt_good = ($urandom % 100) < 6;
         pkt_bad = ($urandom % 100) < 3;
         pkt_dec = ($urandom % 100) < 8;
         if (($urandom % 100) < 3) host_guard = AW'(m_first + AW'($urandom % (int'(AW'(m_last - m_first)) + 1)));
         if (($urandom % 200) == 0) rx_en = ~rx_en;
         if (($urandom % 150) == 0) begin
            host_wr_first = 1; host_first = AW'($urandom);
            host_wr_last = 1; host_last = AW'(host_first + AW'(4 + $urandom % 40));
         end
         step("R2-rand");
      end
      idle();
      step("final");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule